// File: doc/BRIEF.md
# Asynchronous Serial Port with Hardware Flow Control

This block is a self-timed serial transmitter and receiver clocked from the system clock. A divisor input sets the bit time, which is (divisor + 1) system clocks. The transmitter frames each byte with one low start bit, eight data bits sent least significant first, and one high stop bit. The receiver takes the same framing. It can also be set to accept a short character of one to seven data bits, which it places right-aligned in its result.

Each direction has one byte of holding storage. The transmit side can be held back by a clear-to-send input when handshaking is switched on. Once a start bit has gone out, the character always runs to its end. Two interrupt outputs are gated by one shared enable. One reports that the transmitter has drained. The other reports that a received character is waiting.

The control inputs are plain levels that a register file outside the block drives. They are the divisor, the handshake switch, the receive length code and the interrupt enable.

Top module: `serlink_ctrl`

## Requirements
- R1: After reset, ser_txd and rx data sync are high, tx_hold_full, rx_full, rx_overrun, rts, irq_done and irq_rxfull are all 0.
- R2: A transmitted character is a 0 start bit, eight data bits least significant first and a 1 stop bit. Each bit lasts cfg_div+1 clocks.
- R3: A tx_wr while tx_hold_full is 1 is ignored. The waiting byte is the one sent, and no further character follows it.
- R4: With cfg_hs_en=1 and cts=0, no start bit is driven while a byte waits, and rts is 1 while that byte waits.
- R5: After a start bit has been driven, dropping cts does not stop or alter the character.
- R6: With cfg_rx_len=000 the receiver takes eight data bits and presents the whole byte on rx_data.
- R7: With cfg_rx_len=N (1..7) the receiver takes exactly N data bits and then the stop bit. The bits sit in rx_data[N-1:0], and the upper bits are 0.
- R8: A low pulse on ser_rxd that is high again at the mid-point of the start bit produces no character, and the next real character is received correctly.
- R9: rx_full rises when a character is stored and falls on an rx_rd pulse.
- R10: A character that completes while rx_full=1 sets rx_overrun and leaves rx_data unchanged. An rx_rd clears both rx_full and rx_overrun.
- R11: irq_done goes to 1 after a stop bit ends with nothing waiting, and it returns to 0 when a new byte is accepted.
- R12: With cfg_irq_en=0 both irq_done and irq_rxfull stay 0, and the state behind them is kept.
- R13: With cfg_hs_en=0 the level on cts has no effect on transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Bit-time divisor, bit = cfg_div+1 clocks |
| cfg_hs_en | input | 1 | Enables clear-to-send hold-off |
| cfg_rx_len | input | 3 | Receive data bits, 000 = eight |
| cfg_irq_en | input | 1 | Shared enable for both interrupts (1 = on) |
| tx_wr | input | 1 | Write pulse into the transmit holding byte |
| tx_data | input | 8 | Byte to transmit |
| tx_hold_full | output | 1 | Transmit holding byte occupied |
| rx_rd | input | 1 | Read pulse that releases the receive holding byte |
| rx_data | output | 8 | Received character, right-aligned |
| rx_full | output | 1 | Receive holding byte occupied |
| rx_overrun | output | 1 | Sticky: a character arrived while full |
| ser_txd | output | 1 | Serial output, idles high |
| ser_rxd | input | 1 | Serial input, idles high |
| rts | output | 1 | Request to send, when handshake is on |
| cts | input | 1 | Clear to send |
| irq_done | output | 1 | Transmitter drained interrupt |
| irq_rxfull | output | 1 | Receive full interrupt |

## Verification
On every clock, the assertions check four things. A start edge drives the line low. A frame ends on a high level. No start occurs against a low clear-to-send that has passed through the synchronizer. The holding bytes behave as set out in R3 and R10, and a short character never carries bits above its length. Bit timing and bit order on the line, glitch rejection, the partial-length alignment of actual data, and the masking of the interrupts can only be shown by the bench. The bench drives and decodes whole frames at known bit times for those cases.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  localparam int unsigned SL_DATA_W = 8;
  localparam int unsigned SL_LEN_W  = 3;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // number of data bits for a length code (code 0 = full byte)
  function automatic logic [3:0] rx_bits(input logic [SL_LEN_W-1:0] len);
    return (len == '0) ? 4'(SL_DATA_W) : {1'b0, len};
  endfunction

  // bits enter at the top of the shifter; move them down to bit 0
  function automatic logic [SL_DATA_W-1:0] rx_align(input logic [SL_DATA_W-1:0] sr,
                                                   input logic [SL_LEN_W-1:0] len);
    return sr >> (4'(SL_DATA_W) - rx_bits(len));
  endfunction
endpackage

// File: rtl/serlink_sync.sv
module serlink_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serlink_tx.sv
module serlink_tx
  import serlink_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic                 cfg_hs_en,
  input  logic                 cts_ok,
  input  logic                 tx_wr,
  input  logic [SL_DATA_W-1:0] tx_data,
  output logic                 ser_txd,
  output logic                 rts,
  output logic                 hold_vld,
  output logic [SL_DATA_W-1:0] hold_byte,
  output logic                 done_flag,
  output logic                 tx_start,
  output logic                 tx_end
);
  localparam int BL_W = $clog2(SL_DATA_W + 2);

  logic               busy;
  logic [SL_DATA_W:0] sreg;
  logic [DIV_W-1:0]   cnt;
  logic [BL_W-1:0]    bits_left;
  logic               tick;
  logic               accept;

  assign tx_start = hold_vld && !busy && (!cfg_hs_en || cts_ok);
  assign tick     = busy && (cnt == '0);
  assign tx_end   = tick && (bits_left == '0);
  assign accept   = tx_wr && !hold_vld;
  assign rts      = cfg_hs_en && hold_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_byte <= '0;
      done_flag <= 1'b0;
    end else begin
      if (tx_start) hold_vld <= 1'b0;
      if (accept) begin
        hold_vld  <= 1'b1;
        hold_byte <= tx_data;
        done_flag <= 1'b0;
      end else if (tx_end && !hold_vld) begin
        done_flag <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ser_txd   <= 1'b1;
      sreg      <= '1;
      cnt       <= '0;
      bits_left <= '0;
    end else if (tx_start) begin
      busy      <= 1'b1;
      ser_txd   <= 1'b0;
      sreg      <= {1'b1, hold_byte};
      cnt       <= cfg_div;
      bits_left <= BL_W'(SL_DATA_W + 1);
    end else if (tick) begin
      if (bits_left == '0) begin
        busy <= 1'b0;
      end else begin
        ser_txd   <= sreg[0];
        sreg      <= {1'b1, sreg[SL_DATA_W:1]};
        bits_left <= bits_left - 1'b1;
        cnt       <= cfg_div;
      end
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx
  import serlink_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic [SL_LEN_W-1:0]  cfg_rx_len,
  input  logic                 rxd_s,
  input  logic                 rx_rd,
  output logic [SL_DATA_W-1:0] rx_data,
  output logic                 rx_full,
  output logic                 rx_overrun,
  output logic                 rx_deliver,
  output logic [SL_DATA_W-1:0] rx_word
);
  rx_state_e            state;
  logic                 rxd_d;
  logic [DIV_W-1:0]     cnt;
  logic [3:0]           nb;
  logic [SL_DATA_W-1:0] sreg;
  logic                 tick;

  assign tick       = (state != RX_IDLE) && (cnt == '0);
  assign rx_deliver = tick && (state == RX_STOP);
  assign rx_word    = rx_align(sreg, cfg_rx_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      rxd_d <= 1'b1;
      cnt   <= '0;
      nb    <= '0;
      sreg  <= '0;
    end else begin
      rxd_d <= rxd_s;
      if (state == RX_IDLE) begin
        if (rxd_d && !rxd_s) begin
          state <= RX_START;
          cnt   <= cfg_div >> 1;
        end
      end else if (!tick) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= cfg_div;
        unique case (state)
          RX_START: begin
            nb    <= '0;
            state <= rxd_s ? RX_IDLE : RX_DATA;
          end
          RX_DATA: begin
            sreg <= {rxd_s, sreg[SL_DATA_W-1:1]};
            if (nb == rx_bits(cfg_rx_len) - 4'd1) state <= RX_STOP;
            else                                  nb    <= nb + 4'd1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_full    <= 1'b0;
      rx_overrun <= 1'b0;
    end else if (rx_deliver) begin
      rx_full <= 1'b1;
      if (rx_full && !rx_rd) begin
        rx_overrun <= 1'b1;
      end else begin
        rx_data    <= rx_word;
        rx_overrun <= 1'b0;
      end
    end else if (rx_rd) begin
      rx_full    <= 1'b0;
      rx_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serlink_ctrl.sv
module serlink_ctrl
  import serlink_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     cfg_div,
  input  logic                 cfg_hs_en,
  input  logic [SL_LEN_W-1:0]  cfg_rx_len,
  input  logic                 cfg_irq_en,
  input  logic                 tx_wr,
  input  logic [SL_DATA_W-1:0] tx_data,
  output logic                 tx_hold_full,
  input  logic                 rx_rd,
  output logic [SL_DATA_W-1:0] rx_data,
  output logic                 rx_full,
  output logic                 rx_overrun,
  output logic                 ser_txd,
  input  logic                 ser_rxd,
  output logic                 rts,
  input  logic                 cts,
  output logic                 irq_done,
  output logic                 irq_rxfull
);
  logic                 cts_ok;
  logic                 rxd_s;
  logic                 tx_start;
  logic                 tx_end;
  logic                 done_flag;
  logic [SL_DATA_W-1:0] tx_hold_byte;
  logic                 rx_deliver;
  logic [SL_DATA_W-1:0] rx_word;

  serlink_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b0)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts), .q(cts_ok));

  serlink_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_n), .d(ser_rxd), .q(rxd_s));

  serlink_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_hs_en(cfg_hs_en),
    .cts_ok(cts_ok), .tx_wr(tx_wr), .tx_data(tx_data), .ser_txd(ser_txd),
    .rts(rts), .hold_vld(tx_hold_full), .hold_byte(tx_hold_byte),
    .done_flag(done_flag), .tx_start(tx_start), .tx_end(tx_end));

  serlink_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_rx_len(cfg_rx_len),
    .rxd_s(rxd_s), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
    .rx_overrun(rx_overrun), .rx_deliver(rx_deliver), .rx_word(rx_word));

  assign irq_done   = cfg_irq_en && done_flag;
  assign irq_rxfull = cfg_irq_en && rx_full;
endmodule

// File: rtl/serlink_checker.sv
module serlink_checker
  import serlink_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_hs_en,
  input logic [SL_LEN_W-1:0]  cfg_rx_len,
  input logic                 cts,
  input logic                 ser_txd,
  input logic                 tx_wr,
  input logic                 tx_hold_full,
  input logic [SL_DATA_W-1:0] tx_hold_byte,
  input logic                 tx_start,
  input logic                 tx_end,
  input logic                 rx_rd,
  input logic                 rx_deliver,
  input logic [SL_DATA_W-1:0] rx_word,
  input logic                 rx_full,
  input logic [SL_DATA_W-1:0] rx_data,
  input logic                 rx_overrun
);
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !ser_txd);

  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |-> ser_txd);

  a_r3_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_hold_full && !tx_start |=> tx_hold_full && $stable(tx_hold_byte));

  a_r4_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start && cfg_hs_en |-> $past(cts, 2));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_deliver && (cfg_rx_len != '0) |-> ((rx_word >> cfg_rx_len) == '0));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && !rx_deliver |=> !rx_full && !rx_overrun);

  a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full && rx_deliver && !rx_rd |=> rx_overrun && rx_full && $stable(rx_data));
endmodule

bind serlink_ctrl serlink_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hs_en(cfg_hs_en), .cfg_rx_len(cfg_rx_len),
  .cts(cts), .ser_txd(ser_txd), .tx_wr(tx_wr), .tx_hold_full(tx_hold_full),
  .tx_hold_byte(tx_hold_byte), .tx_start(tx_start), .tx_end(tx_end),
  .rx_rd(rx_rd), .rx_deliver(rx_deliver), .rx_word(rx_word),
  .rx_full(rx_full), .rx_data(rx_data), .rx_overrun(rx_overrun));

// File: tb/serlink_ctrl_bench.sv
module serlink_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd3;
  logic        cfg_hs_en = 1'b0;
  logic [2:0]  cfg_rx_len = 3'd0;
  logic        cfg_irq_en = 1'b1;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_hold_full;
  logic        rx_rd = 1'b0;
  logic [7:0]  rx_data;
  logic        rx_full;
  logic        rx_overrun;
  logic        ser_txd;
  logic        ser_rxd = 1'b1;
  logic        rts;
  logic        cts = 1'b0;
  logic        irq_done;
  logic        irq_rxfull;

  int checks = 0;
  int errors = 0;
  int period = 4;

  always #4 clk = ~clk;

  serlink_ctrl u_serlink_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_hs_en(cfg_hs_en),
    .cfg_rx_len(cfg_rx_len), .cfg_irq_en(cfg_irq_en), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_hold_full(tx_hold_full), .rx_rd(rx_rd),
    .rx_data(rx_data), .rx_full(rx_full), .rx_overrun(rx_overrun),
    .ser_txd(ser_txd), .ser_rxd(ser_rxd), .rts(rts), .cts(cts),
    .irq_done(irq_done), .irq_rxfull(irq_rxfull));

  // {length code, bits placed on the line, expected rx_data}
  localparam logic [18:0] RXV [7] = '{
    {3'd0, 8'hA5, 8'hA5},
    {3'd0, 8'h3C, 8'h3C},
    {3'd1, 8'h01, 8'h01},
    {3'd3, 8'hFD, 8'h05},
    {3'd4, 8'h9C, 8'h0C},
    {3'd5, 8'h36, 8'h16},
    {3'd7, 8'hFF, 8'h7F}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic set_div(input int d);
    cfg_div = 16'(d);
    period  = d + 1;
  endtask

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  // drive a frame of nbits data bits onto ser_rxd
  task automatic send_rx(input logic [7:0] b, input int nbits);
    @(negedge clk);
    ser_rxd = 1'b0; repeat (period) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_rxd = b[i]; repeat (period) @(negedge clk);
    end
    ser_rxd = 1'b1; repeat (period + 4) @(negedge clk);
  endtask

  // wait for a start bit and sample every bit at its mid-point
  task automatic capture_tx(input logic drop_cts, output logic [7:0] b,
                            output logic stop_ok, output logic seen);
    int g = 0;
    b = 8'h00; stop_ok = 1'b0; seen = 1'b0;
    while (ser_txd !== 1'b0 && g < 400) begin @(negedge clk); g++; end
    if (ser_txd !== 1'b0) return;
    seen = 1'b1;
    if (drop_cts) cts = 1'b0;
    repeat (period / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (period) @(negedge clk);
      b[i] = ser_txd;
    end
    repeat (period) @(negedge clk);
    stop_ok = (ser_txd === 1'b1);
    repeat (period) @(negedge clk);
  endtask

  // true when ser_txd stays high for n clocks
  task automatic watch_idle(input int n, output logic quiet);
    quiet = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ser_txd !== 1'b1) quiet = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    report();
  end

  initial begin
    logic [7:0] b;
    logic stop_ok, seen, quiet;
    int lo;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(ser_txd === 1'b1, "R1 txd", int'(ser_txd), 1);
    check({tx_hold_full, rx_full, rx_overrun, rts} === 4'b0, "R1 flags",
          int'({tx_hold_full, rx_full, rx_overrun, rts}), 0);
    check({irq_done, irq_rxfull} === 2'b0, "R1 irqs", int'({irq_done, irq_rxfull}), 0);

    // R2 start bit length (bit0 of 0x55 is 1 so the low run is the start bit)
    set_div(3);
    write_tx(8'h55);
    lo = 0;
    while (ser_txd !== 1'b0 && lo < 50) begin @(negedge clk); lo++; end
    lo = 0;
    while (ser_txd === 1'b0 && lo < 50) begin @(negedge clk); lo++; end
    check(lo == period, "R2 start bit clocks", lo, period);
    repeat (12 * period) @(negedge clk);
    // R11 drained
    check(irq_done === 1'b1, "R11 done after drain", int'(irq_done), 1);

    // R2 content, R11 clear on accept
    write_tx(8'hA3);
    check(irq_done === 1'b0, "R11 done cleared", int'(irq_done), 0);
    capture_tx(1'b0, b, stop_ok, seen);
    check(seen && b == 8'hA3, "R2 data lsb first", int'(b), 'hA3);
    check(stop_ok, "R2 stop bit", int'(stop_ok), 1);

    // R4 hold-off and R3 ignored write
    cfg_hs_en = 1'b1; cts = 1'b0;
    write_tx(8'h3C);
    write_tx(8'hC3);
    watch_idle(60, quiet);
    check(quiet, "R4 no start while cts low", int'(quiet), 1);
    check(rts === 1'b1 && tx_hold_full === 1'b1, "R4 rts while waiting",
          int'({rts, tx_hold_full}), 3);
    cts = 1'b1;
    capture_tx(1'b0, b, stop_ok, seen);
    check(seen && b == 8'h3C, "R3 first byte kept", int'(b), 'h3C);
    watch_idle(60, quiet);
    check(quiet, "R3 no second character", int'(quiet), 1);

    // R5 cts drop after start
    write_tx(8'h96);
    capture_tx(1'b1, b, stop_ok, seen);
    check(seen && b == 8'h96 && stop_ok, "R5 completes after cts drop", int'(b), 'h96);

    // R13 handshake off
    cfg_hs_en = 1'b0; cts = 1'b0;
    write_tx(8'h5A);
    capture_tx(1'b0, b, stop_ok, seen);
    check(seen && b == 8'h5A, "R13 cts ignored", int'(b), 'h5A);

    // R6 R7 R9 table loop
    foreach (RXV[i]) begin
      logic [2:0] ln;
      int nb;
      ln = RXV[i][18:16];
      nb = (ln == 3'd0) ? 8 : int'(ln);
      cfg_rx_len = ln;
      send_rx(RXV[i][15:8], nb);
      check(rx_full === 1'b1 && irq_rxfull === 1'b1, "R9 full set",
            int'({rx_full, irq_rxfull}), 3);
      check(rx_data === RXV[i][7:0], (ln == 3'd0) ? "R6 full byte" : "R7 partial",
            int'(rx_data), int'(RXV[i][7:0]));
      read_rx();
      check(rx_full === 1'b0, "R9 cleared by read", int'(rx_full), 0);
    end

    // R10 overrun
    cfg_rx_len = 3'd0;
    send_rx(8'h11, 8);
    send_rx(8'h22, 8);
    check(rx_overrun === 1'b1, "R10 overrun set", int'(rx_overrun), 1);
    check(rx_data === 8'h11, "R10 data kept", int'(rx_data), 'h11);
    read_rx();
    check({rx_full, rx_overrun} === 2'b00, "R10 read clears", int'({rx_full, rx_overrun}), 0);

    // R12 masking
    cfg_irq_en = 1'b0;
    send_rx(8'h44, 8);
    check(rx_full === 1'b1, "R12 state kept", int'(rx_full), 1);
    check({irq_done, irq_rxfull} === 2'b00, "R12 masked", int'({irq_done, irq_rxfull}), 0);
    @(negedge clk); cfg_irq_en = 1'b1;
    @(negedge clk);
    check({irq_done, irq_rxfull} === 2'b11, "R12 unmasked", int'({irq_done, irq_rxfull}), 3);
    read_rx();

    // R8 glitch rejection
    set_div(9);
    @(negedge clk); ser_rxd = 1'b0;
    repeat (2) @(negedge clk); ser_rxd = 1'b1;
    repeat (40) @(negedge clk);
    check(rx_full === 1'b0, "R8 glitch rejected", int'(rx_full), 0);
    send_rx(8'h6B, 8);
    check(rx_full === 1'b1 && rx_data === 8'h6B, "R8 next char ok", int'(rx_data), 'h6B);

    report();
  end
endmodule